// File: doc/BRIEF.md
# Sensor Register Initializer over a Two-Wire Bus

After reset this block configures an image sensor on its own, without any host. It holds a constant list of register writes. Each write is a 16-bit value sent to an 8-bit register address. The block sends every write on a two-wire serial bus (clock and data) that resembles I2C, and it is always the bus master. When the list is finished it raises a completion flag and keeps it high. Downstream control logic waits for that flag before it starts capturing frames.

The work is split between two parts. A sequencer walks the table. It lists the entries of the first register bank, then a bank-select write, then the entries of the second bank. For each entry it starts a frame engine and waits for that engine's done pulse. For every write the engine sends a start condition, four bytes each followed by an acknowledge clock, and a stop condition. It then waits for a bus-free interval.

The engine's timing comes from a quarter-period counter running on the input clock. A quarter lasts `QTR` cycles. With a 13 MHz input clock and the default `QTR` of 32, the serial clock runs at roughly 100 kHz. Both lines are open-drain: an output of 1 means pull the wire low, and 0 means release it to the external pull-up. The block does not sample acknowledge bits, so a missing acknowledge is neither detected nor retried.

Top module: `sensor_reg_init`

## Requirements
- R1: Each write sends, in this order, the device byte 0xB8, the register address, the data high byte and the data low byte. Every byte goes out MSB first, and a 0 bit is sent by pulling the data line low.
- R2: Each byte is followed by a ninth clock slot (the acknowledge slot) during which the data line is released.
- R3: A start is the data line going low while the clock is released, held for 2·QTR cycles before the first clock low. A stop is the data line being released while the clock is released, after a final slot in which data is held low.
- R4: Every bit slot lasts 4·QTR cycles. The clock is pulled low for the first 2·QTR cycles and released for the last 2·QTR cycles.
- R5: The data line changes only while the clock is low, and exactly QTR cycles after the clock's falling edge.
- R6: After each stop both lines stay released for 4·QTR+2 cycles before the next start. The first start follows reset release by one cycle.
- R7: The writes go out in this order: 0x08=0xDD00, 0x48=0x0040, then bank select 0x01=0x0004, then 0x06=0x000A, 0x3B=0x02B0 and 0x5F=0x8984. Exactly six starts and six stops are sent.
- R8: From the cycle after the last write's done pulse, `init_done` is high and stays high, and both lines stay released.
- R9: While `rst_n` is low, both lines are released and `init_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (pixel clock, nominally 13 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_pull_low | output | 1 | 1 pulls the serial clock wire low, 0 releases it |
| sda_pull_low | output | 1 | 1 pulls the serial data wire low, 0 releases it |
| init_done | output | 1 | High and held once every table write has completed |

## Verification
Two events share a cycle at several points. The engine's done pulse lands in the same cycle as the sequencer's table advance or its final completion flag. The shift-register reload for the next byte lands in the last quarter of each acknowledge slot. Both coincidences happen on every write. A per-cycle model of the expected wire levels, built from the requirements, is compared with the outputs on every clock, so an off-by-one at either handover shows up as a level mismatch at that cycle. A separate bus decoder rebuilds the byte stream, the acknowledge slots and the start-to-stop gaps purely from wire transitions.

// File: rtl/cfg_init_pkg.sv
package cfg_init_pkg;

  typedef struct packed {
    logic [7:0]  addr;
    logic [15:0] data;
  } reg_wr_t;

  localparam int unsigned N_WR = 6;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_SLOT, E_FREE, E_DONE
  } eng_st_t;

  typedef enum logic [1:0] {
    S_ISSUE, S_WAIT, S_FIN
  } seq_st_t;

  // bank A entries, bank select, then bank B entries
  function automatic reg_wr_t wr_entry(input int idx);
    case (idx)
      0:       return '{addr: 8'h08, data: 16'hDD00};
      1:       return '{addr: 8'h48, data: 16'h0040};
      2:       return '{addr: 8'h01, data: 16'h0004};
      3:       return '{addr: 8'h06, data: 16'h000A};
      4:       return '{addr: 8'h3B, data: 16'h02B0};
      default: return '{addr: 8'h5F, data: 16'h8984};
    endcase
  endfunction

endpackage

// File: rtl/cfg_quarter_timer.sv
module cfg_quarter_timer #(
  parameter int unsigned QTR = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(QTR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfg_wire_engine.sv
module cfg_wire_engine
  import cfg_init_pkg::*;
#(
  parameter int unsigned QTR = 32,
  parameter logic [7:0]  DEV = 8'hB8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] reg_data,
  output logic        scl_low,
  output logic        sda_low,
  output logic        done,
  output logic        idle
);
  localparam logic [3:0] ACK_BIT  = 4'd8;
  localparam logic [2:0] STOP_IDX = 3'd4;

  eng_st_t    st;
  logic [1:0] qtr;
  logic [3:0] bit_idx;
  logic [2:0] byte_idx;
  logic [7:0] sh;
  logic       sda_q;
  logic       tick;
  logic [7:0] next_byte;
  logic       stop_slot, data_bit, bit_low;

  cfg_quarter_timer #(.QTR(QTR)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(idle), .tick(tick)
  );

  assign idle      = (st == E_IDLE);
  assign done      = (st == E_DONE);
  assign stop_slot = (byte_idx == STOP_IDX);
  assign data_bit  = !stop_slot && (bit_idx != ACK_BIT);
  assign bit_low   = stop_slot ? 1'b1 : ((bit_idx == ACK_BIT) ? 1'b0 : ~sh[7]);

  assign scl_low = (st == E_SLOT) && !qtr[1];
  assign sda_low = (st == E_START) || ((st == E_SLOT) && sda_q);

  always_comb begin
    case (byte_idx + 3'd1)
      3'd1:    next_byte = reg_addr;
      3'd2:    next_byte = reg_data[15:8];
      3'd3:    next_byte = reg_data[7:0];
      default: next_byte = DEV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      qtr      <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      sh       <= '0;
      sda_q    <= 1'b0;
    end else begin
      case (st)
        E_IDLE: if (go) begin
          st       <= E_START;
          qtr      <= '0;
          bit_idx  <= '0;
          byte_idx <= '0;
          sh       <= DEV;
          sda_q    <= 1'b1;
        end
        E_START: if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd1) begin
            st  <= E_SLOT;
            qtr <= '0;
          end
        end
        E_SLOT: if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd0) begin
            sda_q <= bit_low;
            if (data_bit) sh <= {sh[6:0], 1'b0};
          end
          if (qtr == 2'd3) begin
            if (stop_slot) begin
              st <= E_FREE;
            end else if (bit_idx == ACK_BIT) begin
              bit_idx  <= '0;
              byte_idx <= byte_idx + 3'd1;
              sh       <= next_byte;
            end else begin
              bit_idx <= bit_idx + 4'd1;
            end
          end
        end
        E_FREE: if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd3) st <= E_DONE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_init_seq.sv
module cfg_init_seq
  import cfg_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eng_done,
  output logic        go,
  output logic [7:0]  reg_addr,
  output logic [15:0] reg_data,
  output logic        init_done
);
  localparam int unsigned IW = (N_WR > 1) ? $clog2(N_WR) : 1;

  seq_st_t       st;
  logic [IW-1:0] idx;
  reg_wr_t       cur;

  assign cur       = wr_entry(int'(idx));
  assign reg_addr  = cur.addr;
  assign reg_data  = cur.data;
  assign go        = (st == S_ISSUE);
  assign init_done = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_ISSUE;
      idx <= '0;
    end else begin
      case (st)
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (eng_done) begin
          if (idx == IW'(N_WR - 1)) begin
            st <= S_FIN;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_ISSUE;
          end
        end
        default: st <= S_FIN;
      endcase
    end
  end
endmodule

// File: rtl/sensor_reg_init.sv
module sensor_reg_init #(
  parameter int unsigned QTR = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic scl_pull_low,
  output logic sda_pull_low,
  output logic init_done
);
  logic        go, eng_done, eng_idle;
  logic [7:0]  reg_addr;
  logic [15:0] reg_data;

  cfg_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .eng_done(eng_done), .go(go),
    .reg_addr(reg_addr), .reg_data(reg_data), .init_done(init_done)
  );

  cfg_wire_engine #(.QTR(QTR), .DEV(8'hB8)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .reg_addr(reg_addr), .reg_data(reg_data),
    .scl_low(scl_pull_low), .sda_low(sda_pull_low), .done(eng_done), .idle(eng_idle)
  );
endmodule

// File: rtl/sensor_reg_init_chk.sv
module sensor_reg_init_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_low,
  input logic sda_low,
  input logic init_done,
  input logic go,
  input logic eng_idle
);
  // R5: a data change under a low clock needs the clock already low a cycle earlier
  p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_low) && scl_low) |-> $past(scl_low));

  // R3: a start is held with the clock released for more than one cycle
  p_start_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && !scl_low) |=> (sda_low && !scl_low));

  // R3: a stop occurs with the clock released before and after
  p_stop_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_low) && !scl_low) |-> $past(!scl_low));

  // R8: completion is sticky and leaves the bus released
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && !scl_low && !sda_low));

  // R6: a new write is only requested while the engine is idle
  p_go_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> eng_idle);
endmodule

bind sensor_reg_init sensor_reg_init_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_low(scl_pull_low), .sda_low(sda_pull_low),
  .init_done(init_done), .go(go), .eng_idle(eng_idle)
);

// File: tb/sensor_reg_init_tb.sv
module sensor_reg_init_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_pull_low, sda_pull_low, init_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_reg_init #(.QTR(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_pull_low(scl_pull_low),
    .sda_pull_low(sda_pull_low), .init_done(init_done)
  );

  logic [1:0] model[$];      // {scl_low, sda_low} per cycle
  logic [7:0] exp_bytes[24] = '{
    8'hB8, 8'h08, 8'hDD, 8'h00,  8'hB8, 8'h48, 8'h00, 8'h40,
    8'hB8, 8'h01, 8'h00, 8'h04,  8'hB8, 8'h06, 8'h00, 8'h0A,
    8'hB8, 8'h3B, 8'h02, 8'hB0,  8'hB8, 8'h5F, 8'h89, 8'h84};
  logic [7:0] got_bytes[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input int n, input logic scl_l, input logic sda_l);
    for (int i = 0; i < n; i++) model.push_back({scl_l, sda_l});
  endtask

  task automatic build_model();
    for (int w = 0; w < 6; w++) begin
      logic prev, val;
      push(1, 1'b0, 1'b0);
      push(2*Q, 1'b0, 1'b1);
      prev = 1'b1;
      for (int s = 0; s < 37; s++) begin
        if (s == 36)         val = 1'b1;
        else if (s % 9 == 8) val = 1'b0;
        else                 val = ~exp_bytes[w*4 + s/9][7 - (s % 9)];
        push(Q, 1'b1, prev);
        push(Q, 1'b1, val);
        push(2*Q, 1'b0, val);
        prev = val;
      end
      push(4*Q, 1'b0, 1'b0);
      push(1, 1'b0, 1'b0);
    end
  endtask

  // bus decoder state
  bit prev_scl = 1, prev_sda = 1;
  int bitcnt = 0, starts = 0, stops = 0, lowrun = 0, since_stop = 0;
  logic [7:0] curbyte = '0;

  task automatic monitor();
    bit scl, sda;
    scl = !scl_pull_low;
    sda = !sda_pull_low;
    lowrun = scl ? 0 : lowrun + 1;
    if (prev_scl && scl && prev_sda && !sda) begin
      starts++;
      if (stops > 0) chk(since_stop == 4*Q + 2, "R6 bus-free gap", since_stop, 4*Q + 2);
      bitcnt = 0;
      curbyte = '0;
    end
    if (prev_scl && scl && !prev_sda && sda) begin
      stops++;
      since_stop = 0;
    end
    if (!scl && (sda != prev_sda))
      chk(lowrun == Q + 1, "R5 data change point", lowrun, Q + 1);
    if (!prev_scl && scl) begin
      if (bitcnt < 8) begin
        curbyte = {curbyte[6:0], sda};
        bitcnt++;
      end else begin
        chk(sda == 1'b1, "R2 ack slot released", sda, 1);
        got_bytes.push_back(curbyte);
        bitcnt = 0;
        curbyte = '0;
      end
    end
    since_stop++;
    prev_scl = scl;
    prev_sda = sda;
  endtask

  initial begin
    build_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scl_pull_low == 1'b0, "R9 reset scl", scl_pull_low, 0);
    chk(sda_pull_low == 1'b0, "R9 reset sda", sda_pull_low, 0);
    chk(init_done == 1'b0, "R9 reset done", init_done, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    foreach (model[i]) begin
      @(negedge clk);
      chk(scl_pull_low == model[i][1], "R4 clock level", scl_pull_low, model[i][1]);
      chk(sda_pull_low == model[i][0], "R1 data level", sda_pull_low, model[i][0]);
      chk(init_done == 1'b0, "R8 early done", init_done, 0);
      monitor();
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(init_done == 1'b1, "R8 done held", init_done, 1);
      chk(!scl_pull_low && !sda_pull_low, "R8 bus released", {scl_pull_low, sda_pull_low}, 0);
      monitor();
    end
    chk(starts == 6, "R3 start count", starts, 6);
    chk(stops == 6, "R3 stop count", stops, 6);
    chk(got_bytes.size() == 24, "R7 byte count", got_bytes.size(), 24);
    for (int b = 0; b < 24; b++)
      if (b < got_bytes.size())
        chk(got_bytes[b] == exp_bytes[b], "R7 byte order", got_bytes[b], exp_bytes[b]);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule